// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block watches over software with a free-running timer. A two-stage prescaler divides the clock into slow ticks, and an 8-bit up-counter counts those ticks. When the counter passes its top value, the block raises a system reset request. Software keeps the request from happening by loading a fresh start value into the counter before it wraps. A load is accepted only when software has first armed a one-shot load permit. The permit is used up by the load that consumes it.

Three key bits arrive from separate register bits elsewhere in the chip. Together they form a disable key. Only one pattern of the three bits turns the watchdog off, and every other pattern leaves it running. Power-down entry is permitted only while the watchdog is off. Nothing in the block depends on an idle or low-power state, so the watchdog keeps counting while the processor idles.

The control state machine has three states:
- `ST_RUN`: counting.
- `ST_OFF`: disabled by the key. Counter and prescaler are held at zero.
- `ST_FIRE`: the reset request pulse is being driven.

Transitions:
- Reset enters `ST_RUN`.
- `ST_RUN` goes to `ST_FIRE` on counter overflow. Overflow wins over the key.
- `ST_RUN` goes to `ST_OFF` when the key holds the disable pattern.
- `ST_OFF` goes to `ST_RUN` when the key holds any other pattern.
- `ST_FIRE` stays for `RST_CYC` clocks. It then leaves to `ST_OFF` if the key holds the disable pattern, and to `ST_RUN` otherwise.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `sys_rst_req` is 0 and `pd_permit` is 0; the watchdog starts enabled.
- R2: One tick lasts P = `DIV_FACTOR` × 2^`PRE_W` clocks. An accepted load of value C at clock edge E makes `sys_rst_req` rise exactly at edge E + (256 − C)·P.
- R3: On overflow, `sys_rst_req` stays high for exactly `RST_CYC` clocks and then falls. Counter and prescaler restart from zero, so the next request rises 256·P clocks after the pulse ends.
- R4: A write (`wr_en`) made while the load permit is clear is ignored and does not change the time of the next request.
- R5: An accepted load clears the permit, so a later write that is not preceded by a new arming is ignored.
- R6: With {`key_hi`,`key_mid`,`key_lo`} = 3'b101, `pd_permit` reads 1 from the next clock and no request is issued, however long the state lasts.
- R7: Every key value other than 3'b101 keeps the watchdog enabled, with `pd_permit` at 0.
- R8: While the watchdog is disabled, writes are ignored and the count is held at zero. After re-enabling, the next request rises 256·P clocks after the enabling edge.
- R9: When `arm_set` and an accepted write occur on the same clock, the permit stays set, so the following write is also accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the reload data register |
| wr_data | input | CNT_W | Reload value for the counter |
| arm_set | input | 1 | Sets the one-shot load permit |
| key_hi | input | 1 | Disable key, most significant bit |
| key_mid | input | 1 | Disable key, middle bit |
| key_lo | input | 1 | Disable key, least significant bit |
| sys_rst_req | output | 1 | System reset request pulse |
| pd_permit | output | 1 | Power-down entry permitted |

## Verification
Reloads with values 250 and 255 pin the tick length and the countdown formula to the exact edge. A full count from zero after a pulse shows that the counter and prescaler restart cleanly. Unarmed writes, a second write after a consumed permit, and a write that coincides with re-arming separate a permit that is honoured, ignored or kept. Sweeping all eight key values, followed by a long disabled stretch and a re-enable, shows that only one pattern stops the timer and that the count restarts from zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_OFF  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_e;

    localparam int          KEY_W   = 3;
    localparam logic [2:0]  KEY_OFF = 3'b101;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W      = 10,
    parameter int DIV_FACTOR = 304
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int FW = (DIV_FACTOR > 1) ? $clog2(DIV_FACTOR) : 1;

    logic             step;
    logic [PRE_W-1:0] fine_q;

    generate
        if (DIV_FACTOR > 1) begin : g_factor
            localparam logic [FW-1:0] FAC_LAST = FW'(DIV_FACTOR - 1);
            logic [FW-1:0] fac_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fac_q <= '0;
                end else if (clr) begin
                    fac_q <= '0;
                end else if (fac_q == FAC_LAST) begin
                    fac_q <= '0;
                end else begin
                    fac_q <= fac_q + 1'b1;
                end
            end

            assign step = (fac_q == FAC_LAST);
        end else begin : g_no_factor
            assign step = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q <= '0;
        end else if (clr) begin
            fine_q <= '0;
        end else if (step) begin
            fine_q <= fine_q + 1'b1;
        end
    end

    assign tick = !clr && step && (&fine_q);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ovf = tick && !ld && (&cnt_q);

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    input  logic             ovf,
    input  logic             wr_en,
    input  logic             arm_set,
    output logic             ld,
    output logic             hold,
    output logic             wdt_rst,
    output logic             pd_allow
);
    localparam int FCW = $clog2(RST_CYC + 1);
    localparam logic [FCW-1:0] FIRE_LAST = FCW'(RST_CYC - 1);

    wdt_state_e     state_q, state_d;
    logic [FCW-1:0] fire_q;
    logic           arm_q;
    logic           key_off;

    assign key_off = (key == KEY_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ovf)          state_d = ST_FIRE;
                else if (key_off) state_d = ST_OFF;
            end
            ST_OFF: begin
                if (!key_off)     state_d = ST_RUN;
            end
            ST_FIRE: begin
                if (fire_q == FIRE_LAST) state_d = key_off ? ST_OFF : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= '0;
        end else if (state_q == ST_FIRE) begin
            fire_q <= fire_q + 1'b1;
        end else begin
            fire_q <= '0;
        end
    end

    // one-shot load permit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (state_q == ST_FIRE) begin
            arm_q <= 1'b0;
        end else if (arm_set) begin
            arm_q <= 1'b1;
        end else if (ld) begin
            arm_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        wdt_rst  = 1'b0;
        pd_allow = 1'b0;
        hold     = 1'b1;
        ld       = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hold = 1'b0;
                ld   = wr_en && arm_q;
            end
            ST_OFF:  pd_allow = 1'b1;
            ST_FIRE: wdt_rst  = 1'b1;
            default: ;
        endcase
    end

    a_r3_ovf_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> wdt_rst);

    a_r6_key_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst && !ovf && key == KEY_OFF) |=> pd_allow);

    a_r7_key_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        (key != KEY_OFF) |=> !pd_allow);

    a_r6_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        pd_allow |-> !wdt_rst);

    generate
        if (RST_CYC > 1) begin : g_pulse_chk
            a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wdt_rst) |=> wdt_rst);
        end
    endgenerate

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int PRE_W      = 10,
    parameter int DIV_FACTOR = 304,
    parameter int CNT_W      = 8,
    parameter int RST_CYC    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             arm_set,
    input  logic             key_hi,
    input  logic             key_mid,
    input  logic             key_lo,
    output logic             sys_rst_req,
    output logic             pd_permit
);
    import wdt_pkg::*;

    logic [KEY_W-1:0] key;
    logic             tick;
    logic             ovf;
    logic             ld;
    logic             hold;

    assign key = {key_hi, key_mid, key_lo};

    wdt_prescaler #(
        .PRE_W     (PRE_W),
        .DIV_FACTOR(DIV_FACTOR)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (hold | ld),
        .tick (tick)
    );

    wdt_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .ld    (ld),
        .ld_val(wr_data),
        .tick  (tick),
        .ovf   (ovf)
    );

    wdt_ctrl #(
        .RST_CYC(RST_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .key     (key),
        .ovf     (ovf),
        .wr_en   (wr_en),
        .arm_set (arm_set),
        .ld      (ld),
        .hold    (hold),
        .wdt_rst (sys_rst_req),
        .pd_allow(pd_permit)
    );

    a_r8_no_load_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        pd_permit |-> !ld);

endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    localparam int PRE_W   = 2;
    localparam int FAC     = 3;
    localparam int RST_CYC = 4;
    localparam int P       = FAC * (1 << PRE_W);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       arm_set = 1'b0;
    logic       key_hi = 1'b0, key_mid = 1'b0, key_lo = 1'b0;
    logic       sys_rst_req, pd_permit;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    keyed_wdt #(.PRE_W(PRE_W), .DIV_FACTOR(FAC), .CNT_W(8), .RST_CYC(RST_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .arm_set(arm_set), .key_hi(key_hi), .key_mid(key_mid), .key_lo(key_lo),
        .sys_rst_req(sys_rst_req), .pd_permit(pd_permit));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic expect_req(input int e, input bit v, input string tag);
        wait_to(e);
        chk(sys_rst_req == v, tag, sys_rst_req, v);
    endtask

    task automatic arm();
        @(negedge clk); arm_set = 1'b1;
        @(negedge clk); arm_set = 1'b0;
    endtask

    task automatic write(input logic [7:0] v, input bit with_arm, output int e);
        @(negedge clk); wr_en = 1'b1; wr_data = v; arm_set = with_arm;
        @(negedge clk); wr_en = 1'b0; arm_set = 1'b0;
        e = cyc;
    endtask

    task automatic set_key(input logic [2:0] k, output int e);
        @(negedge clk); {key_hi, key_mid, key_lo} = k;
        @(negedge clk);
        e = cyc;
    endtask

    task automatic t_reset();
        chk(sys_rst_req == 1'b0, "R1 req after reset", sys_rst_req, 0);
        chk(pd_permit == 1'b0, "R1 pd_permit after reset", pd_permit, 0);
    endtask

    task automatic t_reload_and_restart();
        int e0, f;
        arm();
        write(8'd250, 1'b0, e0);
        expect_req(e0 + 6*P - 1, 1'b0, "R2 early for 250");
        expect_req(e0 + 6*P, 1'b1, "R2 rise for 250");
        f = e0 + 6*P;
        expect_req(f + RST_CYC - 1, 1'b1, "R3 pulse last cycle");
        expect_req(f + RST_CYC, 1'b0, "R3 pulse ended");
        expect_req(f + RST_CYC + 256*P - 1, 1'b0, "R3 early full count");
        expect_req(f + RST_CYC + 256*P, 1'b1, "R3 rise full count");
        wait_to(f + 2*RST_CYC + 256*P + 1);
    endtask

    task automatic t_top_value();
        int e;
        arm();
        write(8'd255, 1'b0, e);
        expect_req(e + P - 1, 1'b0, "R2 early for 255");
        expect_req(e + P, 1'b1, "R2 rise for 255");
        wait_to(e + P + RST_CYC + 1);
    endtask

    task automatic t_unarmed();
        int e; bit seen = 1'b0;
        write(8'd250, 1'b0, e);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sys_rst_req) seen = 1'b1;
        end
        chk(!seen, "R4 unarmed write ignored", seen, 0);
    endtask

    task automatic t_consumed();
        int e1, e2;
        arm();
        write(8'd250, 1'b0, e1);
        wait_to(e1 + 30);
        write(8'd200, 1'b0, e2);
        expect_req(e1 + 6*P - 1, 1'b0, "R5 early");
        expect_req(e1 + 6*P, 1'b1, "R5 second write ignored");
        wait_to(e1 + 6*P + RST_CYC + 1);
    endtask

    task automatic t_same_cycle();
        int e1, e2;
        write(8'd250, 1'b0, e1);
        arm();
        write(8'd250, 1'b1, e1);
        wait_to(e1 + 20);
        write(8'd250, 1'b0, e2);
        expect_req(e1 + 6*P, 1'b0, "R9 first load superseded");
        expect_req(e2 + 6*P - 1, 1'b0, "R9 early");
        expect_req(e2 + 6*P, 1'b1, "R9 permit kept");
        wait_to(e2 + 6*P + RST_CYC + 1);
    endtask

    task automatic t_keys();
        int e;
        for (int k = 0; k < 8; k++) begin
            if (k != 5) begin
                set_key(3'(k), e);
                @(negedge clk);
                chk(pd_permit == 1'b0, $sformatf("R7 key %0d keeps enabled", k), pd_permit, 0);
            end
        end
        set_key(3'b000, e);
    endtask

    task automatic t_disable();
        int ek, en, e; bit seen = 1'b0;
        set_key(3'b101, ek);
        chk(pd_permit == 1'b1, "R6 pd_permit when off", pd_permit, 1);
        arm();
        write(8'd250, 1'b0, e);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (sys_rst_req || !pd_permit) seen = 1'b1;
        end
        chk(!seen, "R6 no request while off", seen, 0);
        set_key(3'b000, en);
        chk(pd_permit == 1'b0, "R8 pd_permit after enable", pd_permit, 0);
        expect_req(en + 6*P, 1'b0, "R8 write while off ignored");
        expect_req(en + 256*P - 1, 1'b0, "R8 early");
        expect_req(en + 256*P, 1'b1, "R8 restart from zero");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reload_and_restart();
        t_top_value();
        t_unarmed();
        t_consumed();
        t_same_cycle();
        t_keys();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule